// File: doc/BRIEF.md
# Serial Flash Configuration Register Front-End

This block is the target-side command logic of a serial flash device, limited to its status and configuration registers. A host drives chip select (active low), a serial clock and a single data-in line in mode 0. The block samples data in on rising clock edges, drives data out on falling edges, and decodes one command per chip-select frame. The block runs on its own system clock and oversamples the serial pins through two-flop synchronizers.

The block holds two copies of status register 1 and configuration registers 1 to 3. The non-volatile copies are written only by the write-registers command. The volatile copies set runtime behaviour and are reloaded from the non-volatile copies by a software reset. A write-enable latch protects the write-registers command. An accepted register write is followed by a short busy phase, counted in system clock cycles. A four-wire command mode can be entered and left. Only single-bit framing is decoded, so while that mode is set the block accepts only the commands that leave it. Every other frame raises an error flag.

Top module: `flash_cfg_front`

## Requirements
- R1: After rst_ni is released, the volatile and non-volatile registers hold their init parameters, with all defaults 0x00. The write-enable latch is clear and the block is not busy. quad_o, qpi_o, qpi_err_o and so_o are 0.
- R2: Opcode 0x9F returns the 24-bit ID parameter, MSB first, on so_o. so_o changes after falling SCK edges, and each bit is valid at the following rising edge.
- R3: Opcode 0x06, in a frame of exactly 8 bits, sets the write-enable latch. Opcode 0x05 returns the status byte {SR1[7:2], write-enable latch, busy}, with busy at bit 0 and the latch at bit 1. Opcode 0x35 returns volatile configuration register 1.
- R4: Opcode 0x01 with the latch set and exactly 8, 16, 24 or 32 data bits writes, in send order, SR1, then CR1, then CR2, then CR3. It writes as many registers as whole bytes were sent, into both copies. It then clears the latch and sets busy for BUSY_CYC clock cycles.
- R5: Opcode 0x01 with any other data bit count, or with the latch clear, has no effect on any register or on the latch.
- R6: While busy, frames have no effect on registers, the latch or QPI mode. Reads still answer.
- R7: A frame of exactly 0x99 copies every non-volatile register into its volatile copy and clears the latch, but only when the frame just before it was exactly 0x66. Any other frame between them cancels the enable.
- R8: Opcode 0x38 sets QPI mode, which is volatile CR2 bit 3. qpi_o shows CR2 bit 3. quad_o is CR1 bit 1 OR CR2 bit 3.
- R9: Opcode 0xF5 clears QPI mode and leaves CR1 bit 1 unchanged.
- R10: While QPI mode is set, the only frames that act are exact 8-bit frames of 0xF5, 0x66 and 0x99. Every other frame is ignored, returns zeros, and sets qpi_err_o from its end until the next CS# fall.
- R11: so_o is 0 while CS# is high and during the opcode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, mode 0 |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| quad_o | output | 1 | Four-bit data width in effect |
| qpi_o | output | 1 | QPI mode flag (volatile CR2 bit 3) |
| qpi_err_o | output | 1 | Last frame was refused because QPI mode was set |

## Verification
The assertions check on every cycle that:
- so_o stays low outside a frame;
- a register write that starts busy leaves the latch clear;
- nothing in the register state moves while busy;
- leaving QPI mode never disturbs the quad bit;
- the error flag rises only in QPI mode;
- the latch rises only at a frame end.

Only the bench scenarios can show which bit counts the write-registers command accepts and which bytes land where. The bench sweeps every count from 0 to 40. The scenarios also cover the reset-enable pairing and its cancellation, and the split between volatile and non-volatile copies. That split shows when QPI mode set by opcode is lost on reset, while QPI mode written by register survives it.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;
  localparam int CNT_W  = 6;
  localparam int DATA_W = 32;
  localparam int NREG   = 4;
  localparam int RESP_W = 24;
  localparam int QPI_BIT  = 3;
  localparam int QUAD_BIT = 1;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRR   = 8'h01;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_RDCR1 = 8'h35;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_RSTEN = 8'h66;
  localparam logic [7:0] OP_RST   = 8'h99;
  localparam logic [7:0] OP_QPIEN = 8'h38;
  localparam logic [7:0] OP_QPIEX = 8'hF5;

  localparam logic [CNT_W-1:0] LEN_OP = 6'd8;

  typedef logic [NREG-1:0][7:0] reg_bank_t;
endpackage

// File: rtl/cfgf_rx.sv
module cfgf_rx
  import cfgf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              cs_act_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              sck_fall_o,
  output logic              op_done_o,
  output logic [7:0]        op_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [1:0] cs_sync, sck_sync, si_sync;
  logic       sck_q, cs_act_q;
  logic       cs_now, sck_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync  <= 2'b11;
      sck_sync <= 2'b00;
      si_sync  <= 2'b00;
      sck_q    <= 1'b0;
      cs_act_q <= 1'b0;
    end else begin
      cs_sync  <= {cs_sync[0], cs_ni};
      sck_sync <= {sck_sync[0], sck_i};
      si_sync  <= {si_sync[0], si_i};
      sck_q    <= sck_sync[1];
      cs_act_q <= ~cs_sync[1];
    end
  end

  assign cs_now        = ~cs_sync[1];
  assign frame_start_o = cs_now & ~cs_act_q;
  assign frame_end_o   = ~cs_now & cs_act_q;
  assign sck_rise      = cs_now & cs_act_q & sck_sync[1] & ~sck_q;
  assign sck_fall_o    = cs_act_q & ~sck_sync[1] & sck_q;
  assign cs_act_o      = cs_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o      <= '0;
      data_o    <= '0;
      cnt_o     <= '0;
      op_done_o <= 1'b0;
    end else begin
      op_done_o <= sck_rise && (cnt_o == LEN_OP - 6'd1);
      if (frame_start_o) begin
        op_o   <= '0;
        data_o <= '0;
        cnt_o  <= '0;
      end else if (sck_rise) begin
        if (cnt_o < LEN_OP) op_o <= {op_o[6:0], si_sync[1]};
        else                data_o <= {data_o[DATA_W-2:0], si_sync[1]};
        if (cnt_o != '1) cnt_o <= cnt_o + 6'd1;  // saturate on long frames
      end
    end
  end
endmodule

// File: rtl/cfgf_regs.sv
module cfgf_regs
  import cfgf_pkg::*;
#(
  parameter int          BUSY_CYC = 800,
  parameter logic [7:0]  SR1_INIT = 8'h00,
  parameter logic [7:0]  CR1_INIT = 8'h00,
  parameter logic [7:0]  CR2_INIT = 8'h00,
  parameter logic [7:0]  CR3_INIT = 8'h00,
  parameter logic [23:0] DEV_ID   = 24'hC2_40_17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic [7:0]        op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [RESP_W-1:0] resp_o,
  output logic [7:0]        cr1_o,
  output logic              wel_o,
  output logic              busy_o,
  output logic              qpi_o,
  output logic              quad_o,
  output logic              qpi_err_o
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam reg_bank_t INIT = {CR3_INIT, CR2_INIT, CR1_INIT, SR1_INIT};

  reg_bank_t         nv_q, v_q;
  logic [BW-1:0]     busy_cnt_q;
  logic              wel_q, arm_q, err_q;
  logic              busy, qpi, len8, wrr_len;
  logic [CNT_W-1:0]  dbits;
  logic [2:0]        nb;
  logic [DATA_W-1:0] wr_data;

  assign busy    = busy_cnt_q != '0;
  assign qpi     = v_q[2][QPI_BIT];
  assign len8    = cnt_i == LEN_OP;
  assign wrr_len = (cnt_i >= 6'd16) && (cnt_i <= 6'd40) && (cnt_i[2:0] == 3'd0);
  assign dbits   = cnt_i - LEN_OP;
  assign nb      = dbits[5:3];
  // left-align so the first byte sent (SR1) sits in the top byte
  assign wr_data = data_i << {3'd4 - nb, 3'b000};

  always_comb begin
    resp_o = '0;
    if (!qpi) begin
      unique case (op_i)
        OP_RDSR:  resp_o = {v_q[0][7:2], wel_q, busy, 16'h0000};
        OP_RDCR1: resp_o = {v_q[1], 16'h0000};
        OP_RDID:  resp_o = DEV_ID;
        default:  resp_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q       <= INIT;
      v_q        <= INIT;
      busy_cnt_q <= '0;
      wel_q      <= 1'b0;
      arm_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (busy) busy_cnt_q <= busy_cnt_q - 1'b1;
      if (frame_start_i) err_q <= 1'b0;
      if (frame_end_i) arm_q <= len8 && (op_i == OP_RSTEN) && !busy;
      if (frame_end_i && !busy) begin
        if (qpi) begin
          if (len8 && op_i == OP_QPIEX) v_q[2][QPI_BIT] <= 1'b0;
          else if (len8 && op_i == OP_RST && arm_q) begin
            v_q   <= nv_q;
            wel_q <= 1'b0;
          end else if (!(len8 && op_i == OP_RSTEN)) err_q <= 1'b1;
        end else if (len8) begin
          unique case (op_i)
            OP_WREN:  wel_q <= 1'b1;
            OP_QPIEN: v_q[2][QPI_BIT] <= 1'b1;
            OP_QPIEX: v_q[2][QPI_BIT] <= 1'b0;
            OP_RST: if (arm_q) begin
              v_q   <= nv_q;
              wel_q <= 1'b0;
            end
            default: ;
          endcase
        end else if (op_i == OP_WRR && wrr_len && wel_q) begin
          for (int k = 0; k < NREG; k++) begin
            if (k < int'(nb)) begin
              nv_q[k] <= wr_data[8*(NREG-1-k) +: 8];
              v_q[k]  <= wr_data[8*(NREG-1-k) +: 8];
            end
          end
          wel_q      <= 1'b0;
          busy_cnt_q <= BW'(BUSY_CYC);
        end
      end
    end
  end

  assign cr1_o     = v_q[1];
  assign wel_o     = wel_q;
  assign busy_o    = busy;
  assign qpi_o     = qpi;
  assign quad_o    = v_q[1][QUAD_BIT] | qpi;
  assign qpi_err_o = err_q;
endmodule

// File: rtl/cfgf_tx.sv
module cfgf_tx
  import cfgf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              load_i,
  input  logic [RESP_W-1:0] resp_i,
  input  logic              fall_i,
  output logic              so_o
);
  logic [RESP_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      so_o <= 1'b0;
    end else if (!cs_act_i) begin
      sh_q <= '0;
      so_o <= 1'b0;
    end else if (load_i) begin
      sh_q <= resp_i;
    end else if (fall_i) begin
      so_o <= sh_q[RESP_W-1];
      sh_q <= {sh_q[RESP_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/flash_cfg_front.sv
module flash_cfg_front
  import cfgf_pkg::*;
#(
  parameter int          BUSY_CYC = 800,
  parameter logic [7:0]  SR1_INIT = 8'h00,
  parameter logic [7:0]  CR1_INIT = 8'h00,
  parameter logic [7:0]  CR2_INIT = 8'h00,
  parameter logic [7:0]  CR3_INIT = 8'h00,
  parameter logic [23:0] DEV_ID   = 24'hC2_40_17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic quad_o,
  output logic qpi_o,
  output logic qpi_err_o
);
  logic              cs_act, frame_start, frame_end, sck_fall, op_done;
  logic [7:0]        op;
  logic [DATA_W-1:0] data;
  logic [CNT_W-1:0]  cnt;
  logic [RESP_W-1:0] resp;
  logic [7:0]        cr1_v;
  logic              wel, busy;

  cfgf_rx i_rx (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .cs_act_o(cs_act), .frame_start_o(frame_start), .frame_end_o(frame_end),
    .sck_fall_o(sck_fall), .op_done_o(op_done),
    .op_o(op), .data_o(data), .cnt_o(cnt)
  );

  cfgf_regs #(
    .BUSY_CYC(BUSY_CYC), .SR1_INIT(SR1_INIT), .CR1_INIT(CR1_INIT),
    .CR2_INIT(CR2_INIT), .CR3_INIT(CR3_INIT), .DEV_ID(DEV_ID)
  ) i_regs (
    .clk_i, .rst_ni,
    .frame_start_i(frame_start), .frame_end_i(frame_end),
    .op_i(op), .data_i(data), .cnt_i(cnt),
    .resp_o(resp), .cr1_o(cr1_v), .wel_o(wel), .busy_o(busy),
    .qpi_o, .quad_o, .qpi_err_o
  );

  cfgf_tx i_tx (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .load_i(op_done),
    .resp_i(resp), .fall_i(sck_fall), .so_o
  );
endmodule

// File: rtl/flash_cfg_front_chk.sv
module flash_cfg_front_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_act,
  input logic       frame_end,
  input logic       so_o,
  input logic       qpi_o,
  input logic       qpi_err_o,
  input logic       wel,
  input logic       busy,
  input logic [7:0] cr1_v
);
  // R11
  so_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !so_o);

  // R4
  wel_clr_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !wel);

  // R6
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy) |-> ($stable(cr1_v) && $stable(qpi_o) && $stable(wel)));

  // R9
  qpi_exit_quad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(qpi_o) |-> $stable(cr1_v));

  // R10
  err_in_qpi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qpi_err_o) |-> qpi_o);

  // R3
  wel_at_frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel) |-> $past(frame_end));
endmodule

bind flash_cfg_front flash_cfg_front_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_act(cs_act), .frame_end(frame_end),
  .so_o(so_o), .qpi_o(qpi_o), .qpi_err_o(qpi_err_o),
  .wel(wel), .busy(busy), .cr1_v(cr1_v)
);

// File: tb/test_flash_cfg_front.sv
`timescale 1ns/1ps
module test_flash_cfg_front;
  localparam int          HALF  = 8;
  localparam int          BUSY  = 800;
  localparam logic [23:0] ID    = 24'h5A_3C_81;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, quad, qpi, qerr;
  int   n_chk = 0, n_bad = 0;

  logic [7:0] m_reg [4];
  logic       m_wel;
  logic [31:0] rd;

  always #5 clk = ~clk;

  flash_cfg_front #(.BUSY_CYC(BUSY), .DEV_ID(ID)) i_flash_cfg_front (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .quad_o(quad), .qpi_o(qpi), .qpi_err_o(qerr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] op, input int nbits, input logic [39:0] d,
                      output logic [31:0] r);
    r = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8 + nbits; i++) begin
      sck = 1'b0;
      si  = (i < 8) ? op[7-i] : d[nbits-1-(i-8)];
      repeat (HALF) @(negedge clk);
      if (i >= 8) r = {r[30:0], so};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [31:0] r;
    xfer(op, 0, '0, r);
  endtask

  function automatic logic [7:0] exp_sr(input logic busy);
    return {m_reg[0][7:2], m_wel, busy};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_reg[k] = 8'h00;
    m_wel = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R11 reset state
    chk("R1 quad", {31'd0, quad}, 0);
    chk("R1 qpi", {31'd0, qpi}, 0);
    chk("R1 err", {31'd0, qerr}, 0);
    chk("R11 so idle", {31'd0, so}, 0);
    xfer(8'h05, 8, '0, rd);  chk("R1 status", rd, 0);
    xfer(8'h35, 8, '0, rd);  chk("R1 cr1", rd, 0);

    // R2 ID read
    xfer(8'h9F, 24, '0, rd); chk("R2 id", rd, {8'h00, ID});
    chk("R11 so after frame", {31'd0, so}, 0);

    // R3 write enable
    cmd(8'h06); m_wel = 1'b1;
    xfer(8'h05, 8, '0, rd);  chk("R3 wel", rd, {24'd0, exp_sr(1'b0)});

    // R4/R5 sweep of write-registers data bit counts
    for (int n = 0; n <= 40; n++) begin
      logic [7:0]  p [5];
      logic [39:0] full, d;
      logic        acc;
      for (int k = 0; k < 5; k++) p[k] = 8'(n*29 + k*77 + 5);
      p[2][3] = 1'b0;  // keep QPI mode off during the sweep
      full = {p[0], p[1], p[2], p[3], p[4]};
      d    = full >> (40 - n);
      cmd(8'h06); m_wel = 1'b1;
      xfer(8'h01, n, d, rd);
      acc = (n == 8) || (n == 16) || (n == 24) || (n == 32);
      if (acc) begin
        for (int k = 0; k < n/8; k++) m_reg[k] = p[k];
        m_wel = 1'b0;
      end
      xfer(8'h05, 8, '0, rd);
      chk(acc ? "R4 status accepted" : "R5 status discarded", rd, {24'd0, exp_sr(acc)});
      xfer(8'h35, 8, '0, rd);
      chk(acc ? "R4 cr1 accepted" : "R5 cr1 discarded", rd, {24'd0, m_reg[1]});
      chk("R4 qpi stays off", {31'd0, qpi}, 0);
      if (acc) repeat (BUSY) @(negedge clk);
    end

    // R5 write without latch
    cmd(8'h06);
    xfer(8'h01, 16, {24'd0, m_reg[0], 8'h02}, rd);
    m_reg[1] = 8'h02; m_wel = 1'b0;
    repeat (BUSY) @(negedge clk);
    xfer(8'h01, 16, {24'd0, 8'h00, 8'h00}, rd);
    xfer(8'h35, 8, '0, rd);  chk("R5 no latch cr1", rd, 32'h02);
    chk("R8 quad from cr1", {31'd0, quad}, 1);

    // R8/R9/R10 QPI enter, refusal, exit
    cmd(8'h38);
    chk("R8 qpi set", {31'd0, qpi}, 1);
    xfer(8'h9F, 24, '0, rd); chk("R10 id zero in qpi", rd, 0);
    chk("R10 err set", {31'd0, qerr}, 1);
    cmd(8'hF5);
    chk("R9 qpi clr", {31'd0, qpi}, 0);
    chk("R10 err clr on next frame", {31'd0, qerr}, 0);
    chk("R9 quad kept", {31'd0, quad}, 1);
    xfer(8'h35, 8, '0, rd);  chk("R9 cr1 kept", rd, 32'h02);
    cmd(8'h06);
    xfer(8'h01, 16, {24'd0, m_reg[0], 8'h00}, rd);
    m_reg[1] = 8'h00;
    repeat (BUSY) @(negedge clk);
    cmd(8'h38); chk("R8 quad via qpi", {31'd0, quad}, 1);
    cmd(8'hF5); chk("R9 quad off", {31'd0, quad}, 0);

    // R7 reset pairing, volatile reload
    cmd(8'h38); cmd(8'h66); cmd(8'h99);
    chk("R7 reload clears volatile qpi", {31'd0, qpi}, 0);
    chk("R10 reset allowed in qpi", {31'd0, qerr}, 0);
    cmd(8'h38); cmd(8'h66); cmd(8'h06); cmd(8'h99);
    chk("R7 cancelled in qpi", {31'd0, qpi}, 1);
    chk("R10 err after refused", {31'd0, qerr}, 1);
    cmd(8'hF5);
    cmd(8'h06); m_wel = 1'b1;
    cmd(8'h66);
    xfer(8'h05, 8, '0, rd);
    cmd(8'h99);
    xfer(8'h05, 8, '0, rd);  chk("R7 cancel keeps wel", rd, {24'd0, exp_sr(1'b0)});
    cmd(8'h66); cmd(8'h99); m_wel = 1'b0;
    xfer(8'h05, 8, '0, rd);  chk("R7 reset clears wel", rd, {24'd0, exp_sr(1'b0)});

    // R6 busy ignores commands
    cmd(8'h06);
    xfer(8'h01, 8, {32'd0, 8'hA4}, rd);
    m_reg[0] = 8'hA4; m_wel = 1'b0;
    cmd(8'h38);
    chk("R6 qpi ignored busy", {31'd0, qpi}, 0);
    cmd(8'h06);
    xfer(8'h05, 8, '0, rd);  chk("R6 busy status", rd, 32'hA5);
    repeat (BUSY) @(negedge clk);
    xfer(8'h05, 8, '0, rd);  chk("R6 busy done", rd, 32'hA4);

    // R4/R7 QPI written to non-volatile copy survives reset
    cmd(8'h06);
    xfer(8'h01, 24, {16'd0, 8'hA4, 8'h00, 8'h08}, rd);
    chk("R4 cr2 write sets qpi", {31'd0, qpi}, 1);
    repeat (BUSY) @(negedge clk);
    cmd(8'h66); cmd(8'h99);
    chk("R7 nv qpi reloaded", {31'd0, qpi}, 1);
    cmd(8'hF5);
    chk("R9 exit", {31'd0, qpi}, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule